// File: doc/BRIEF.md
# Resynchronizable Frame-Sync Generator

This block turns an external reference clock into a divided bit clock and a frame-sync pulse. All of its logic runs in the system clock domain. The reference clock and the external frame-sync input are first passed through flop synchronizers. The rising edges of the synchronized inputs then act as one-cycle strobes that step the divider and the frame logic. The divided clock, called the bit clock here, advances once per reference rising edge. Its own rising edges mark the bit-clock cycles that the frame logic counts.

The block has two modes, chosen by a mode input. In free mode, frames repeat on a programmable period counted in bit-clock cycles, and the external frame-sync input has no effect. In locked mode, frames start only on a rising edge of the external frame-sync input, and the period setting is ignored. Each such edge also realigns the divider phase, so that the next reference rising edge becomes a bit-clock rising edge. A frame pulse that is already high is stretched by a new frame start, because the width count restarts. A change of the mode input is applied only while the frame pulse is low.

Top module: `fsync_gen`

## Requirements
- R1: While reset is high, and on the first sample after reset is asserted, `bclk_out` and `fsync_out` are 0. Reset preloads the divider so that the first reference rising edge after reset is a bit-clock rising edge.
- R2: Each external input goes through a two-flop synchronizer. An output change caused by an input change appears in the third system-clock cycle after the input changes.
- R3: `bclk_out` rises on every (`div_val`+1)th reference rising edge. It stays high for floor((`div_val`+2)/2) reference periods and is low for the rest of the cycle. With `div_val` = 0 it stays high.
- R4: In free mode (`sync_mode` = 0), `fsync_out` rises only together with a `bclk_out` rising edge. The first rise comes on the first bit-clock edge after reset or after free mode takes effect. Later rises are `per_val`+1 bit-clock cycles apart.
- R5: `fsync_out` falls on the (`wid_val`+1)th bit-clock rising edge after the latest frame start.
- R6: In free mode, activity on `ext_fs_in` changes neither the frame spacing nor the frame width.
- R7: In locked mode (`sync_mode` = 1), `fsync_out` rises only in response to a rising edge of `ext_fs_in`, three cycles after that edge. No frame is produced without such an edge, whatever the value of `per_val`.
- R8: In locked mode, a rising edge on `ext_fs_in` drives `bclk_out` low and reloads the divider. The next reference rising edge is then a bit-clock rising edge.
- R9: In locked mode, a rising edge on `ext_fs_in` while `fsync_out` is high restarts the width count, so the pulse stays high without a gap.
- R10: A change of `sync_mode` takes effect only in a cycle where `fsync_out` is low. While a frame is high, the mode that started the frame stays in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_clk_in | input | 1 | External reference clock, asynchronous |
| ext_fs_in | input | 1 | External frame-sync input, asynchronous |
| div_val | input | 8 | Divide value; bit clock = reference / (div_val+1) |
| per_val | input | 12 | Frame period minus one, in bit-clock cycles (free mode) |
| wid_val | input | 8 | Frame pulse width minus one, in bit-clock cycles |
| sync_mode | input | 1 | 0 = free mode, 1 = locked to external frame sync |
| bclk_out | output | 1 | Divided bit clock |
| fsync_out | output | 1 | Frame-sync pulse |

## Verification
A wrong divider count shows up within one bit-clock cycle as a shifted `bclk_out` edge or a wrong duty split. A wrong frame counter shows up within one frame period as a wrong spacing between `fsync_out` rises. A wrong width counter shows up at the first falling edge of a frame. A stale mode or a missed resync shows up within the same frame: a spurious frame appears in locked mode, the frame fails to stretch, or the bit-clock rise does not land on the first reference edge after the external pulse. The bench measures all of these intervals exactly, in system-clock cycles.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

    // Default widths of the configuration fields.
    localparam int unsigned FSG_DIV_W       = 8;
    localparam int unsigned FSG_PER_W       = 12;
    localparam int unsigned FSG_WID_W       = 8;
    localparam int unsigned FSG_SYNC_STAGES = 2;

    // Source of frame starts.
    typedef enum logic {
        MODE_FREE = 1'b0,
        MODE_SYNC = 1'b1
    } fsg_mode_e;

    // Divider action for the current system-clock cycle.
    typedef enum logic [1:0] {
        DIV_HOLD   = 2'd0,
        DIV_STEP   = 2'd1,
        DIV_RELOAD = 2'd2
    } fsg_div_op_e;

    // Picks the divider action: a resync overrides a reference edge.
    function automatic fsg_div_op_e div_op(input logic resync, input logic ref_edge);
        if (resync)
            return DIV_RELOAD;
        else if (ref_edge)
            return DIV_STEP;
        else
            return DIV_HOLD;
    endfunction

endpackage

// File: rtl/fsg_edge_sync.sv
module fsg_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    logic [STAGES-1:0] stg;
    logic              last_q;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[0] <= 1'b0;
                else     stg[0] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[i] <= 1'b0;
                else     stg[i] <= stg[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b0;
        else     last_q <= stg[STAGES-1];
    end

    assign rise = stg[STAGES-1] & ~last_q;

endmodule

// File: rtl/fsg_clkdiv.sv
module fsg_clkdiv
    import fsg_pkg::*;
#(
    parameter int unsigned DIV_W = FSG_DIV_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_edge,
    input  logic             resync,
    input  logic [DIV_W-1:0] div_val,
    output logic             tick,
    output logic             bclk
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             level;
    } div_state_t;

    div_state_t  st, st_nx;
    fsg_div_op_e op;
    logic        wrap;
    logic [DIV_W-1:0] cnt_inc;
    logic [DIV_W:0]   high_len;

    assign op       = div_op(resync, ref_edge);
    assign wrap     = (st.cnt >= div_val);
    assign cnt_inc  = wrap ? '0 : st.cnt + DIV_W'(1);
    assign high_len = ({1'b0, div_val} + (DIV_W+1)'(2)) >> 1;

    always_comb begin
        st_nx = st;
        case (op)
            DIV_RELOAD: begin
                st_nx.cnt   = div_val;
                st_nx.level = 1'b0;
            end
            DIV_STEP: begin
                st_nx.cnt   = cnt_inc;
                st_nx.level = ({1'b0, cnt_inc} < high_len);
            end
            default: st_nx = st;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= '{cnt: '1, level: 1'b0};
        else     st <= st_nx;
    end

    assign tick = (op == DIV_STEP) && wrap;
    assign bclk = st.level;

endmodule

// File: rtl/fsg_framer.sv
module fsg_framer
    import fsg_pkg::*;
#(
    parameter int unsigned PER_W = FSG_PER_W,
    parameter int unsigned WID_W = FSG_WID_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             ext_rise,
    input  logic             sync_req,
    input  logic [PER_W-1:0] per_val,
    input  logic [WID_W-1:0] wid_val,
    output logic             frame,
    output logic             locked
);
    typedef struct packed {
        logic [PER_W-1:0] pcnt;
        logic [WID_W-1:0] wcnt;
        logic             active;
        fsg_mode_e        mode;
    } frm_state_t;

    frm_state_t st, st_nx;
    logic       start;

    always_comb begin
        if (st.mode == MODE_SYNC) start = ext_rise;
        else                      start = tick && (st.pcnt == '0);
    end

    always_comb begin
        st_nx = st;
        // Period counter only runs in free mode.
        if (st.mode == MODE_SYNC)
            st_nx.pcnt = '0;
        else if (tick)
            st_nx.pcnt = (st.pcnt >= per_val) ? '0 : st.pcnt + PER_W'(1);
        // Pulse width.
        if (start) begin
            st_nx.active = 1'b1;
            st_nx.wcnt   = '0;
        end else if (tick && st.active) begin
            if (st.wcnt >= wid_val) st_nx.active = 1'b0;
            else                    st_nx.wcnt   = st.wcnt + WID_W'(1);
        end
        // Mode is adopted only between frames.
        if (!st.active)
            st_nx.mode = sync_req ? MODE_SYNC : MODE_FREE;
    end

    always_ff @(posedge clk) begin
        if (rst) st <= '{pcnt: '0, wcnt: '0, active: 1'b0, mode: MODE_FREE};
        else     st <= st_nx;
    end

    assign frame  = st.active;
    assign locked = (st.mode == MODE_SYNC);

endmodule

// File: rtl/fsync_gen.sv
module fsync_gen
    import fsg_pkg::*;
#(
    parameter int unsigned DIV_W       = FSG_DIV_W,
    parameter int unsigned PER_W       = FSG_PER_W,
    parameter int unsigned WID_W       = FSG_WID_W,
    parameter int unsigned SYNC_STAGES = FSG_SYNC_STAGES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ext_clk_in,
    input  logic             ext_fs_in,
    input  logic [DIV_W-1:0] div_val,
    input  logic [PER_W-1:0] per_val,
    input  logic [WID_W-1:0] wid_val,
    input  logic             sync_mode,
    output logic             bclk_out,
    output logic             fsync_out
);
    logic ck_rise;
    logic fs_rise;
    logic clk_tick;
    logic mode_is_sync;
    logic resync;

    fsg_edge_sync #(.STAGES(SYNC_STAGES)) u_ck_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (ext_clk_in),
        .rise (ck_rise)
    );

    fsg_edge_sync #(.STAGES(SYNC_STAGES)) u_fs_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (ext_fs_in),
        .rise (fs_rise)
    );

    assign resync = mode_is_sync && fs_rise;

    fsg_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst      (rst),
        .ref_edge (ck_rise),
        .resync   (resync),
        .div_val  (div_val),
        .tick     (clk_tick),
        .bclk     (bclk_out)
    );

    fsg_framer #(.PER_W(PER_W), .WID_W(WID_W)) u_frm (
        .clk      (clk),
        .rst      (rst),
        .tick     (clk_tick),
        .ext_rise (fs_rise),
        .sync_req (sync_mode),
        .per_val  (per_val),
        .wid_val  (wid_val),
        .frame    (fsync_out),
        .locked   (mode_is_sync)
    );

endmodule

// File: rtl/fsync_gen_chk.sv
module fsync_gen_chk (
    input logic clk,
    input logic rst,
    input logic bclk_out,
    input logic fsync_out,
    input logic mode_sync,
    input logic clk_tick,
    input logic ck_rise,
    input logic fs_rise
);
    // R1
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!bclk_out && !fsync_out));

    // R3
    a_r3_bclk_rise_on_ref_edge: assert property (@(posedge clk) disable iff (rst)
        $rose(bclk_out) |-> $past(ck_rise));

    // R4
    a_r4_free_frame_on_tick: assert property (@(posedge clk) disable iff (rst)
        ($rose(fsync_out) && !$past(mode_sync)) |-> $past(clk_tick));

    // R5
    a_r5_frame_ends_on_tick: assert property (@(posedge clk) disable iff (rst)
        $fell(fsync_out) |-> $past(clk_tick));

    // R7
    a_r7_locked_frame_needs_edge: assert property (@(posedge clk) disable iff (rst)
        ($rose(fsync_out) && $past(mode_sync)) |-> $past(fs_rise));

    // R10
    a_r10_mode_held_in_frame: assert property (@(posedge clk) disable iff (rst)
        $past(fsync_out) |-> $stable(mode_sync));

endmodule

bind fsync_gen fsync_gen_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bclk_out  (bclk_out),
    .fsync_out (fsync_out),
    .mode_sync (mode_is_sync),
    .clk_tick  (clk_tick),
    .ck_rise   (ck_rise),
    .fs_rise   (fs_rise)
);

// File: tb/fsync_gen_test.sv
module fsync_gen_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ext_clk_in = 1'b0;
    logic        ext_fs_in = 1'b0;
    logic [7:0]  div_val = 8'd0;
    logic [11:0] per_val = 12'd0;
    logic [7:0]  wid_val = 8'd0;
    logic        sync_mode = 1'b0;
    logic        bclk_out;
    logic        fsync_out;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    int k = 2;
    int hc = 0;
    int last_rise = 0;
    int rise_cnt = 0;
    bit ext_run = 1'b0;
    bit fs_noise = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Reference clock with half period k, and optional frame-sync noise.
    always @(negedge clk) begin
        if (ext_run) begin
            if (hc >= k - 1) begin
                hc = 0;
                ext_clk_in = ~ext_clk_in;
                if (ext_clk_in) begin
                    last_rise = cyc;
                    rise_cnt++;
                end
            end else begin
                hc++;
            end
        end
        if (fs_noise) ext_fs_in = 1'($urandom_range(0, 1));
    end

    fsync_gen uut (
        .clk        (clk),
        .rst        (rst),
        .ext_clk_in (ext_clk_in),
        .ext_fs_in  (ext_fs_in),
        .div_val    (div_val),
        .per_val    (per_val),
        .wid_val    (wid_val),
        .sync_mode  (sync_mode),
        .bclk_out   (bclk_out),
        .fsync_out  (fsync_out)
    );

    function automatic int clkg_len(int d, int kk);
        return (d + 1) * 2 * kk;
    endfunction

    function automatic int high_len(int d, int kk);
        return ((d + 2) / 2) * 2 * kk;
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Waits for a transition of bclk_out (sel=0) or fsync_out (sel=1) to lvl.
    task automatic wait_sig(input bit sel, input bit lvl, input int limit, output int t);
        bit prev;
        bit v;
        prev = sel ? fsync_out : bclk_out;
        t = -1;
        for (int i = 0; i < limit; i++) begin
            step();
            v = sel ? fsync_out : bclk_out;
            if (v == lvl && prev != lvl) begin
                t = cyc;
                break;
            end
            prev = v;
        end
    endtask

    task automatic setup(input int d, input int f, input int w, input bit m, input int kk);
        rst = 1'b1;
        ext_run = 1'b0;
        fs_noise = 1'b0;
        ext_clk_in = 1'b0;
        ext_fs_in = 1'b0;
        hc = 0;
        k = kk;
        div_val = 8'(d);
        per_val = 12'(f);
        wid_val = 8'(w);
        sync_mode = m;
        repeat (3) step();
        rise_cnt = 0;
        rst = 1'b0;
    endtask

    // Raises ext_fs_in s cycles after the next reference rise is seen.
    task automatic pulse_fs(input int s, output int tp, output int rn);
        int r0;
        r0 = rise_cnt;
        for (int i = 0; i < 200 && rise_cnt == r0; i++) step();
        rn = last_rise + 2 * k;
        repeat (s) step();
        ext_fs_in = 1'b1;
        tp = cyc;
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        int t1, t2, t3, ta, tb, tc, tp, rn, tp2, rn2, cnt, first;
        int d, f, w, s;
        void'($urandom(32'h1f2e3d4c));

        // R1: reset holds outputs low while the reference runs.
        setup(0, 0, 0, 1'b0, 2);
        rst = 1'b1;
        ext_run = 1'b1;
        cnt = 0;
        for (int i = 0; i < 20; i++) begin
            step();
            if (bclk_out || fsync_out) cnt++;
        end
        chk("R1", "outputs high during reset", cnt, 0);

        // R2: latency from one reference edge to the first bit clock and frame.
        setup(0, 0, 0, 1'b0, 2);
        repeat (4) step();
        ext_clk_in = 1'b1;
        tc = cyc;
        wait_sig(1'b0, 1'b1, 20, ta);
        chk("R2", "bclk rise latency", ta - tc, 3);
        chk("R1", "frame on first bit-clock edge", int'(fsync_out), 1);

        // R3: divide by one keeps bclk high.
        setup(0, 3, 0, 1'b0, 2);
        ext_run = 1'b1;
        wait_sig(1'b0, 1'b1, 50, ta);
        cnt = 0;
        for (int i = 0; i < 100; i++) begin
            step();
            if (!bclk_out) cnt++;
        end
        chk("R3", "low samples at div 0", cnt, 0);

        // R3 R4 R5: directed free-mode frame (div 2, period 3, width 1).
        setup(2, 3, 1, 1'b0, 2);
        ext_run = 1'b1;
        wait_sig(1'b1, 1'b1, 500, t1);
        chk("R4", "first frame after first ref edge", t1 - last_rise, 3);
        chk("R4", "bclk high at frame start", int'(bclk_out), 1);
        wait_sig(1'b1, 1'b0, 500, t2);
        wait_sig(1'b1, 1'b1, 500, t3);
        chk("R5", "frame width", t2 - t1, 2 * clkg_len(2, 2));
        chk("R4", "frame spacing", t3 - t1, 4 * clkg_len(2, 2));
        wait_sig(1'b0, 1'b1, 500, ta);
        wait_sig(1'b0, 1'b0, 500, tb);
        wait_sig(1'b0, 1'b1, 500, tc);
        chk("R3", "bclk high time div 2", tb - ta, high_len(2, 2));
        chk("R3", "bclk period div 2", tc - ta, clkg_len(2, 2));

        // R3: even split at div 3.
        setup(3, 2, 0, 1'b0, 3);
        ext_run = 1'b1;
        wait_sig(1'b0, 1'b1, 500, ta);
        wait_sig(1'b0, 1'b0, 500, tb);
        wait_sig(1'b0, 1'b1, 500, tc);
        chk("R3", "bclk high time div 3", tb - ta, high_len(3, 3));
        chk("R3", "bclk period div 3", tc - ta, clkg_len(3, 3));

        // R6: noise on the external frame-sync input in free mode.
        setup(1, 3, 0, 1'b0, 2);
        ext_run = 1'b1;
        wait_sig(1'b1, 1'b1, 500, t1);
        fs_noise = 1'b1;
        wait_sig(1'b1, 1'b0, 500, t2);
        wait_sig(1'b1, 1'b1, 500, t3);
        fs_noise = 1'b0;
        ext_fs_in = 1'b0;
        chk("R6", "width under noise", t2 - t1, clkg_len(1, 2));
        chk("R6", "spacing under noise", t3 - t1, 4 * clkg_len(1, 2));
        // R1: reset in mid-run clears outputs on the next sample.
        rst = 1'b1;
        step();
        chk("R1", "outputs after mid-run reset", int'(bclk_out) + int'(fsync_out), 0);
        rst = 1'b0;

        // R7: locked mode, period 0, no external pulse: no frames, bclk keeps running.
        setup(1, 0, 0, 1'b1, 2);
        ext_run = 1'b1;
        cnt = 0;
        first = 0;
        for (int i = 0; i < 400; i++) begin
            step();
            if (fsync_out) cnt++;
            if (bclk_out) first++;
        end
        chk("R7", "frame samples without pulse", cnt, 0);
        chk("R3", "bclk active in locked mode", int'(first > 100), 1);

        // R7 R8 R5: locked-mode pulses at random phases.
        for (int it = 0; it < 4; it++) begin
            d = $urandom_range(1, 3);
            w = $urandom_range(1, 3);
            k = $urandom_range(3, 4);
            s = $urandom_range(0, 2 * k - 3);
            setup(d, $urandom_range(0, 7), w, 1'b1, k);
            ext_run = 1'b1;
            repeat (30) step();
            pulse_fs(s, tp, rn);
            wait_sig(1'b1, 1'b1, 50, t1);
            ext_fs_in = 1'b0;
            chk("R7", "frame latency from pulse", t1 - tp, 3);
            wait_sig(1'b0, 1'b1, 200, ta);
            chk("R8", "bclk realigned to next ref edge", ta, rn + 3);
            wait_sig(1'b1, 1'b0, 500, t2);
            chk("R5", "locked frame fall", t2, rn + w * clkg_len(d, k) + 3);
        end

        // R9: second pulse while the frame is high restarts the width.
        setup(1, 0, 2, 1'b1, 3);
        ext_run = 1'b1;
        repeat (20) step();
        pulse_fs(0, tp, rn);
        wait_sig(1'b1, 1'b1, 50, t1);
        ext_fs_in = 1'b0;
        pulse_fs(0, tp2, rn2);
        wait_sig(1'b1, 1'b0, 500, t2);
        ext_fs_in = 1'b0;
        chk("R9", "stretched frame fall", t2, rn2 + 2 * clkg_len(1, 3) + 3);

        // R10: mode change requested mid-frame waits for the frame to end.
        setup(1, 5, 3, 1'b1, 3);
        ext_run = 1'b1;
        repeat (20) step();
        pulse_fs(0, tp, rn);
        wait_sig(1'b1, 1'b1, 50, t1);
        ext_fs_in = 1'b0;
        sync_mode = 1'b0;
        pulse_fs(0, tp2, rn2);
        wait_sig(1'b1, 1'b0, 500, t2);
        ext_fs_in = 1'b0;
        chk("R10", "locked mode kept during frame", t2, rn2 + 3 * clkg_len(1, 3) + 3);
        wait_sig(1'b1, 1'b1, 500, t3);
        chk("R10", "free frame after switch", t3 - t2, clkg_len(1, 3));

        // R4 R5 R3: random free-mode settings.
        for (int it = 0; it < 6; it++) begin
            d = $urandom_range(1, 4);
            f = $urandom_range(1, 5);
            w = $urandom_range(0, f - 1);
            setup(d, f, w, 1'b0, $urandom_range(2, 4));
            ext_run = 1'b1;
            wait_sig(1'b1, 1'b1, 3000, t1);
            wait_sig(1'b1, 1'b0, 3000, t2);
            wait_sig(1'b1, 1'b1, 3000, t3);
            chk("R5", "random frame width", t2 - t1, (w + 1) * clkg_len(d, k));
            chk("R4", "random frame spacing", t3 - t1, (f + 1) * clkg_len(d, k));
            wait_sig(1'b0, 1'b1, 500, ta);
            wait_sig(1'b0, 1'b0, 500, tb);
            wait_sig(1'b0, 1'b1, 500, tc);
            chk("R3", "random bclk high", tb - ta, high_len(d, k));
            chk("R3", "random bclk period", tc - ta, clkg_len(d, k));
        end

        summary();
    end

endmodule